// File: doc/BRIEF.md
# SPI Slave Shift Engine

This block is the serial core of an SPI slave. It runs entirely on a system clock. The external serial clock, select and data-in lines pass through two-flop synchronizers. Serial clock transitions are detected inside the system clock domain. The master's serial clock must therefore run at no more than one quarter of the system clock rate.

Each transfer has a configuration made of four settings: idle clock level, phase, bit order and word length (8 or 16 bits). The configuration is taken when select falls and is held until select rises again. A configuration change made during a transfer therefore has no effect on it.

Each bit takes two serial clock edges. On one edge the data-in line is captured into a one-bit latch. On the other edge that latched bit is moved into the receive shift register. The reply word supplied on `tx_data_i` is driven out on `miso_o`. When a full word has been received it is copied to `rx_data_o`, and a sticky completion flag is raised. The flag stays set until a clear pulse arrives.

Top module: `spi_slave_engine`

## Requirements
- R1: While `ss_ni` is high, `miso_oe_o` and `miso_o` stay low. Serial clock toggles and data-in activity while `ss_ni` is high leave `done_o`, `rx_data_o` and the bit position of the next transfer unchanged.
- R2: With `cpha_i`=0, `miso_o` shows the first reply bit after select falls and before any serial clock edge. Data-in is captured on odd edges and shifted in on even edges.
- R3: With `cpha_i`=1, `miso_o` presents the first reply bit only after the first serial clock edge. Data-in is captured on even edges and shifted in on odd edges. The final bit is taken in on the last edge of the word.
- R4: An odd-numbered edge is a serial clock transition away from the idle level given by `cpol_i` (0 = idle low, 1 = idle high). All four combinations of `cpol_i` and `cpha_i` exchange words correctly.
- R5: With `lsb_first_i`=1, bit 0 of the reply is sent first and the first received bit lands in bit 0 of the word. With `lsb_first_i`=0, the most significant bit of the word is sent and received first.
- R6: With `wide_i`=0, a word is 8 bits: the reply is taken from `tx_data_i[7:0]`, and `rx_data_o[15:8]` reads zero. With `wide_i`=1, a word is 16 bits.
- R7: When the configured number of bits has been shifted in, the word is copied to `rx_data_o` and `done_o` is set. `rx_data_o` holds that value until the next completed word.
- R8: `done_o` stays set until a one-cycle `done_clr_i` pulse clears it. A completion that arrives in the same cycle as a clear leaves the flag set.
- R9: Raising `ss_ni` before a word is complete discards the partial word. `done_o` is not set, `rx_data_o` is unchanged, and the next transfer starts from its first bit.
- R10: The four configuration inputs are sampled when select falls. Changing them while select is low does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| ss_ni | input | 1 | Slave select, active low (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| cpol_i | input | 1 | Idle serial clock level |
| cpha_i | input | 1 | Clock phase select |
| lsb_first_i | input | 1 | 1 = least significant bit first |
| wide_i | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| tx_data_i | input | 16 | Reply word, sampled at select fall and after each completed word |
| done_clr_i | input | 1 | Clear pulse for the completion flag |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | High while the slave drives `miso_o` |
| rx_data_o | output | 16 | Last received word |
| done_o | output | 1 | Sticky transfer-complete flag |

## Verification
Two cases are hard to reach from the ports. One is the phase-set transfer, where the last bit has no odd edge after its capture edge. The other is an aborted word, whose leftover bit count would only show up in a later transfer. The bench handles both with a master task that can drop select after any chosen bit. It then runs a full transfer and compares that word against the scoreboard. The same task can also flip the bit order and the word length in the middle of a word. The expected word stays the one implied by the configuration at select fall, so any use of the live inputs shows up as a mismatch.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic wide;
  } spi_cfg_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned            WIDTH   = 3,
  parameter int unsigned            STAGES  = 2,
  parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_edge_unit.sv
module spi_edge_unit
  import spi_slave_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sck_s_i,
  input  logic     ss_n_s_i,
  input  spi_cfg_t cfg_i,
  output logic     start_o,
  output logic     active_o,
  output logic     sample_o,
  output logic     shift_o,
  output logic     cpha_o,
  output logic     lsb_first_o,
  output logic     wide_o
);
  logic     active_q, sck_q;
  spi_cfg_t cfg_q, cfg_eff;
  logic     edge_seen, odd_edge, even_edge;

  assign start_o = !active_q && !ss_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      cfg_q    <= '0;
    end else begin
      active_q <= !ss_n_s_i;
      sck_q    <= sck_s_i;
      if (start_o) cfg_q <= cfg_i;
    end
  end

  // configuration is live only in the select-fall cycle, frozen afterwards
  assign cfg_eff   = start_o ? cfg_i : cfg_q;
  assign edge_seen = active_q && (sck_s_i != sck_q);
  assign odd_edge  = edge_seen && (sck_s_i != cfg_q.cpol);
  assign even_edge = edge_seen && (sck_s_i == cfg_q.cpol);
  assign sample_o  = cfg_q.cpha ? even_edge : odd_edge;
  assign shift_o   = cfg_q.cpha ? odd_edge  : even_edge;

  assign active_o    = active_q;
  assign cpha_o      = cfg_eff.cpha;
  assign lsb_first_o = cfg_eff.lsb_first;
  assign wide_o      = cfg_eff.wide;

  p_edge_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, shift_o}));
  p_no_edge_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sample_o && !shift_o);
  p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !ss_n_s_i |=> $stable(cfg_q));
endmodule

// File: rtl/spi_slave_datapath.sv
module spi_slave_datapath #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              mosi_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              done_clr_i,
  output logic              miso_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [CNT_W-1:0]  bit_cnt_q, nbits;
  logic [IDX_W-1:0]  top_idx;
  logic [DATA_W-1:0] rx_sr_q, rx_nxt, tx_sr_q, rx_data_q, word_mask;
  logic              latch_q, have_q, miso_q, done_q;
  logic              last_bit, take_last, do_shift, in_bit, complete;

  function automatic logic head_of(logic [DATA_W-1:0] w, logic lsb, logic [IDX_W-1:0] top);
    return lsb ? w[0] : w[top];
  endfunction

  function automatic logic [DATA_W-1:0] advance(logic [DATA_W-1:0] w, logic lsb);
    return lsb ? (w >> 1) : (w << 1);
  endfunction

  assign nbits     = wide_i ? CNT_W'(DATA_W) : CNT_W'(NARROW_W);
  assign top_idx   = wide_i ? IDX_W'(DATA_W-1) : IDX_W'(NARROW_W-1);
  assign word_mask = wide_i ? '1 : NARROW_MASK;
  assign last_bit  = (bit_cnt_q == nbits - CNT_W'(1));
  // phase set: the last bit has no later odd edge, take it on its capture edge
  assign take_last = cpha_i && sample_i && last_bit;
  assign do_shift  = (shift_i && have_q) || take_last;
  assign in_bit    = take_last ? mosi_i : latch_q;
  assign complete  = do_shift && last_bit;

  always_comb begin
    if (lsb_first_i) begin
      rx_nxt          = rx_sr_q >> 1;
      rx_nxt[top_idx] = in_bit;
    end else begin
      rx_nxt = {rx_sr_q[DATA_W-2:0], in_bit};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
      rx_data_q <= '0;
      latch_q   <= 1'b0;
      have_q    <= 1'b0;
      miso_q    <= 1'b0;
    end else if (start_i || complete) begin
      bit_cnt_q <= '0;
      have_q    <= 1'b0;
      rx_sr_q   <= '0;
      if (complete) rx_data_q <= rx_nxt & word_mask;
      if (!cpha_i) begin
        miso_q  <= head_of(tx_data_i, lsb_first_i, top_idx);
        tx_sr_q <= advance(tx_data_i, lsb_first_i);
      end else begin
        tx_sr_q <= tx_data_i;
        if (start_i) miso_q <= 1'b0;
      end
    end else if (!active_i) begin
      bit_cnt_q <= '0;
      have_q    <= 1'b0;
    end else begin
      if (sample_i && !take_last) begin
        latch_q <= mosi_i;
        have_q  <= 1'b1;
      end
      if (do_shift) begin
        rx_sr_q   <= rx_nxt;
        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
        have_q    <= 1'b0;
      end
      if (shift_i) begin
        miso_q  <= head_of(tx_sr_q, lsb_first_i, top_idx);
        tx_sr_q <= advance(tx_sr_q, lsb_first_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else if (complete) done_q <= 1'b1;
    else if (done_clr_i) done_q <= 1'b0;
  end

  assign miso_o    = miso_q;
  assign rx_data_o = rx_data_q;
  assign done_o    = done_q;

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !start_i |-> bit_cnt_q < nbits);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete |=> done_q);
  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !done_clr_i |=> done_q);
  p_rx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !complete |=> $stable(rx_data_q));
  p_abort_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i && !start_i |=> bit_cnt_q == '0);
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NARROW_W    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              done_clr_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o
);
  logic [2:0] sync_q;
  logic       sck_s, ss_n_s, mosi_s;
  logic       start, active, sample_ev, shift_ev;
  logic       cpha_eff, lsb_eff, wide_eff, miso_raw;
  spi_cfg_t   cfg_in;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, mosi_i}),
    .q_o   (sync_q)
  );
  assign {sck_s, ss_n_s, mosi_s} = sync_q;

  assign cfg_in = '{cpol: cpol_i, cpha: cpha_i, lsb_first: lsb_first_i, wide: wide_i};

  spi_edge_unit u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_s_i    (sck_s),
    .ss_n_s_i   (ss_n_s),
    .cfg_i      (cfg_in),
    .start_o    (start),
    .active_o   (active),
    .sample_o   (sample_ev),
    .shift_o    (shift_ev),
    .cpha_o     (cpha_eff),
    .lsb_first_o(lsb_eff),
    .wide_o     (wide_eff)
  );

  spi_slave_datapath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .active_i   (active),
    .sample_i   (sample_ev),
    .shift_i    (shift_ev),
    .mosi_i     (mosi_s),
    .cpha_i     (cpha_eff),
    .lsb_first_i(lsb_eff),
    .wide_i     (wide_eff),
    .tx_data_i  (tx_data_i),
    .done_clr_i (done_clr_i),
    .miso_o     (miso_raw),
    .rx_data_o  (rx_data_o),
    .done_o     (done_o)
  );

  assign miso_oe_o = active;
  assign miso_o    = active && miso_raw;

  p_miso_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_n_s |=> !miso_oe_o && !miso_o);
endmodule

// File: tb/spi_slave_engine_tb_top.sv
module spi_slave_engine_tb_top;
  localparam int HALF = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck_i = 1'b0, ss_ni = 1'b1, mosi_i = 1'b0;
  logic        cpol_i = 1'b0, cpha_i = 1'b0, lsb_first_i = 1'b0, wide_i = 1'b0;
  logic [15:0] tx_data_i = '0;
  logic        done_clr_i = 1'b0;
  logic        miso_o, miso_oe_o, done_o;
  logic [15:0] rx_data_o;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  spi_slave_engine dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .ss_ni(ss_ni), .mosi_i(mosi_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .lsb_first_i(lsb_first_i), .wide_i(wide_i),
    .tx_data_i(tx_data_i), .done_clr_i(done_clr_i), .miso_o(miso_o),
    .miso_oe_o(miso_oe_o), .rx_data_o(rx_data_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor: every completion pops one expected word
  initial begin
    forever begin
      @(posedge done_o);
      @(negedge clk_i);
      if (exp_q.size() == 0) check(0, "R7 unexpected completion", {16'h0, rx_data_o}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rx_data_o == e, "R7/R5/R6 received word", {16'h0, rx_data_o}, {16'h0, e});
      end
    end
  end

  // master driver: stop_at < n aborts the word, flip_at changes config mid-word
  task automatic xfer(input bit cpol, input bit cpha, input bit lsb, input bit wide,
                      input logic [15:0] mo, input logic [15:0] tx,
                      input int stop_at, input int flip_at, input string tag);
    int n;
    logic [15:0] mask, got;
    bit aborted;
    n = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    got = '0;
    aborted = stop_at < n;
    cpol_i = cpol; cpha_i = cpha; lsb_first_i = lsb; wide_i = wide; tx_data_i = tx;
    sck_i = cpol; ss_ni = 1'b1;
    wait_clk(8);
    if (!aborted) exp_q.push_back(mo & mask);
    ss_ni = 1'b0;
    if (!cpha) mosi_i = lsb ? mo[0] : mo[n-1];
    wait_clk(HALF);
    for (int i = 0; i < n; i++) begin
      if (i == stop_at) break;
      if (i == flip_at) begin lsb_first_i = !lsb; wide_i = !wide; end
      if (!cpha) begin
        got[lsb ? i : n-1-i] = miso_o;
        sck_i = ~sck_i; wait_clk(HALF);
        sck_i = ~sck_i;
        if (i + 1 < n) mosi_i = lsb ? mo[i+1] : mo[n-2-i];
        wait_clk(HALF);
      end else begin
        sck_i = ~sck_i;
        mosi_i = lsb ? mo[i] : mo[n-1-i];
        wait_clk(HALF);
        got[lsb ? i : n-1-i] = miso_o;
        sck_i = ~sck_i; wait_clk(HALF);
      end
    end
    ss_ni = 1'b1;
    cpol_i = cpol; cpha_i = cpha; lsb_first_i = lsb; wide_i = wide;
    wait_clk(10);
    if (!aborted) check(got == (tx & mask), {tag, " reply on miso"}, {16'h0, got}, {16'h0, tx & mask});
  endtask

  task automatic close_word();
    check(done_o == 1'b1, "R7 done after word", {31'h0, done_o}, 32'h1);
    wait_clk(20);
    check(done_o == 1'b1, "R8 done sticky", {31'h0, done_o}, 32'h1);
    done_clr_i = 1'b1; wait_clk(1); done_clr_i = 1'b0; wait_clk(2);
    check(done_o == 1'b0, "R8 done cleared", {31'h0, done_o}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(0, "watchdog", 32'h0, 32'h1);
    report();
  end

  initial begin
    logic [15:0] held;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);
    check(miso_oe_o == 1'b0 && miso_o == 1'b0, "R1 reset idle miso", {30'h0, miso_oe_o, miso_o}, 32'h0);
    check(done_o == 1'b0 && rx_data_o == 16'h0, "R7 reset state", {15'h0, done_o, rx_data_o}, 32'h0);

    xfer(0, 0, 0, 0, 16'h00A5, 16'h003C, 99, 99, "R2 mode0");
    close_word();
    xfer(0, 1, 0, 0, 16'h005A, 16'h00C3, 99, 99, "R3 mode1");
    close_word();
    xfer(1, 0, 0, 0, 16'h0096, 16'h0071, 99, 99, "R4 mode2");
    close_word();
    xfer(1, 1, 0, 0, 16'h001E, 16'h00E8, 99, 99, "R4 mode3");
    close_word();
    xfer(0, 0, 1, 0, 16'h000D, 16'h00B0, 99, 99, "R5 lsb-first");
    close_word();
    xfer(1, 1, 0, 1, 16'hBEEF, 16'h1234, 99, 99, "R6 16-bit msb");
    close_word();
    xfer(0, 1, 1, 1, 16'hC0DE, 16'h4A71, 99, 99, "R6 16-bit lsb");
    close_word();
    xfer(0, 0, 0, 0, 16'hFF3C, 16'hAB5D, 99, 99, "R6 narrow upper ignored");
    close_word();

    // R9: abort after three bits, then a clean word
    held = rx_data_o;
    xfer(0, 0, 0, 0, 16'h00F0, 16'h0011, 3, 99, "R9 abort");
    wait_clk(20);
    check(done_o == 1'b0, "R9 no done on abort", {31'h0, done_o}, 32'h0);
    check(rx_data_o == held, "R9 rx unchanged on abort", {16'h0, rx_data_o}, {16'h0, held});
    xfer(0, 0, 0, 0, 16'h006B, 16'h0092, 99, 99, "R9 after abort");
    close_word();

    // R1: serial clock activity with select high
    held = rx_data_o;
    for (int k = 0; k < 12; k++) begin
      sck_i = ~sck_i; mosi_i = k[0];
      wait_clk(HALF);
      check(miso_oe_o == 1'b0 && miso_o == 1'b0, "R1 miso quiet", {30'h0, miso_oe_o, miso_o}, 32'h0);
    end
    check(done_o == 1'b0 && rx_data_o == held, "R1 idle clocks ignored", {15'h0, done_o, rx_data_o}, {16'h0, held});
    xfer(1, 0, 0, 0, 16'h0047, 16'h00C9, 99, 99, "R1 after idle clocks");
    close_word();

    // R10: order and width flipped mid-word
    xfer(0, 0, 0, 0, 16'h00D2, 16'h005E, 99, 4, "R10 cfg change");
    close_word();

    check(exp_q.size() == 0, "R7 all words completed", exp_q.size(), 32'h0);
    report();
  end
endmodule